// File: doc/BRIEF.md
# Write-Phase Turnaround Arbiter

This block decides, cycle by cycle, whether a memory data bus is given to the read queue or to the write queue. It tracks how full both queues are through push and pop strobes. When no read is ready to go, it opens a write phase with a one-cycle trigger pulse. It closes the phase once any one of its exit rules is met. After that it holds the bus through a fixed write-to-read turnaround before it lets reads through again.

The exit rules work as a hysteresis. A write phase opens only once the write occupancy is above a low watermark, and it ends once the occupancy falls below that watermark. A drain request cancels the watermark. When it is held, writes carry on until the write queue is empty. A minimum-writes rule lets waiting reads take the bus back once enough writes have gone out in the current phase. Both watermarks are fixed when the block is elaborated, as truncated percentages of the write queue depth.

Top module: `wr_turnaround_arb`

## Requirements
- R1: While reset is held and after it is released, `bus_dir` is 0 (read), `rd_allow` is 1, `phase_cnt`, `wr_occ` and `rd_occ` are 0, and `wr_start` and `rd_resume` are 0.
- R2: The low mark is WQ_DEPTH*LO_PCT/100 and the high mark is WQ_DEPTH*HI_PCT/100, both truncated. LO_PCT >= HI_PCT is rejected at elaboration. `wq_above_hi` is 1 exactly when `wr_occ` >= the high mark.
- R3: A push is taken only when its queue is not full. `rd_occ` drops on `rq_pop` when it is non-zero. `wr_occ` drops only on an accepted write completion. Occupancy never exceeds the queue depth.
- R4: In read direction, with `rd_cand` low, `wr_occ` non-zero, and either `wr_occ` > the low mark or `drain_req` high, the next cycle shows `bus_dir` = 1 (write) with `wr_start` high for that one cycle. Otherwise the block stays in read direction.
- R5: No further `wr_start` is raised while `bus_dir` is 1 or 2, whatever the inputs.
- R6: An accepted write completion (`wr_done` high while `bus_dir` is 1 and `wr_occ` is non-zero) raises `phase_cnt` by one. The count saturates at 2**PHASE_W-1.
- R7: The write phase ends on an accepted completion if, taking the occupancy after that completion (including a push accepted in the same cycle), the queue is empty, or the occupancy is below the low mark with `drain_req` low, or `rd_occ` is non-zero and the incremented phase count is at least MIN_WR.
- R8: When a phase ends, `bus_dir` becomes 2 (turnaround) and `phase_cnt` becomes 0 on the same edge. After exactly TWTR cycles in turnaround, `bus_dir` returns to 0 with `rd_resume` high for one cycle. `rd_allow` is low for the whole time in direction 1 or 2.
- R9: While `drain_req` is high, the low mark neither blocks the start of a phase nor ends one, so writes go on until the write queue is empty.
- R10: A `wr_done` outside the write direction is ignored: neither `wr_occ` nor `phase_cnt` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wq_push | input | 1 | A write request joins the write queue |
| rq_push | input | 1 | A read request joins the read queue |
| rq_pop | input | 1 | A read request leaves the read queue |
| rd_cand | input | 1 | A read is ready to be issued |
| drain_req | input | 1 | Flush all writes and ignore the low mark |
| wr_done | input | 1 | One write has completed on the bus |
| bus_dir | output | 2 | 0 read, 1 write, 2 write-to-read turnaround |
| wr_start | output | 1 | One-cycle pulse opening a write phase |
| rd_resume | output | 1 | One-cycle pulse when reads regain the bus |
| rd_allow | output | 1 | Reads may be granted |
| wq_above_hi | output | 1 | Write occupancy at or above the high mark |
| wr_occ | output | $clog2(WQ_DEPTH+1) | Write queue occupancy |
| rd_occ | output | $clog2(RQ_DEPTH+1) | Read queue occupancy |
| phase_cnt | output | PHASE_W | Writes completed in the current phase |

## Verification
The hardest state to reach from the ports is the saturated phase count. To get there, the write phase has to stay open for more than 2**PHASE_W-1 completions. That only happens when drain is held and writes are pushed as fast as they complete, with the read queue empty. A directed sequence holds exactly that pattern for several hundred cycles. It then lets the queue run empty so the drained phase ends. Random stimulus then mixes drain, pushes and completions so that all three exit rules fire under different orders of arrival. Those random runs include completions arriving in the same cycle as a push to a full queue.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic [1:0] {
      BUS_RD   = 2'd0,
      BUS_WR   = 2'd1,
      BUS_TURN = 2'd2
   } bus_dir_e;

   function automatic int pct_of(input int depth, input int pct);
      return (depth * pct) / 100;
   endfunction
endpackage

// File: rtl/arb_occ_ctr.sv
module arb_occ_ctr #(
   parameter int DEPTH = 32,
   localparam int OW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [OW-1:0] occ
);
   localparam logic [OW-1:0] DEPTH_V = OW'(DEPTH);

   always_ff @(posedge clk) begin
      if (!rst_n)
         occ <= '0;
      else if (inc && !dec)
         occ <= occ + 1'b1;
      else if (dec && !inc)
         occ <= occ - 1'b1;
   end

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= DEPTH_V);
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc) |-> (occ != '0));
endmodule

// File: rtl/arb_wtr_timer.sv
module arb_wtr_timer #(
   parameter int TWTR = 6,
   localparam int TW  = $clog2(TWTR + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy,
   output logic expire
);
   localparam logic [TW-1:0] TWTR_V = TW'(TWTR);
   logic [TW-1:0] tcnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         tcnt <= '0;
      else if (load)
         tcnt <= TWTR_V;
      else if (tcnt != '0)
         tcnt <= tcnt - 1'b1;
   end

   assign busy   = (tcnt != '0);
   assign expire = (tcnt == TW'(1));

   a_r8_load_full: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (tcnt == TWTR_V));
endmodule

// File: rtl/arb_phase_fsm.sv
module arb_phase_fsm
   import arb_pkg::*;
#(
   parameter int WQ_DEPTH = 32,
   parameter int LO_MARK  = 16,
   parameter int MIN_WR   = 4,
   parameter int PHASE_W  = 8,
   parameter int WQ_OW    = 6,
   parameter int RQ_OW    = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_cand,
   input  logic               drain_req,
   input  logic [WQ_OW-1:0]   wr_occ,
   input  logic [RQ_OW-1:0]   rd_occ,
   input  logic               wpush_acc,
   input  logic               wpop_acc,
   input  logic               tmr_expire,
   output logic               tmr_load,
   output bus_dir_e           dir,
   output logic [PHASE_W-1:0] phase_cnt,
   output logic               wr_start,
   output logic               rd_resume
);
   localparam logic [WQ_OW-1:0]   LO_V   = WQ_OW'(LO_MARK);
   localparam logic [PHASE_W-1:0] MIN_V  = PHASE_W'(MIN_WR);
   localparam logic [PHASE_W-1:0] CNT_MX = '1;

   logic [WQ_OW-1:0]   post_occ;
   logic [PHASE_W-1:0] cnt_inc;
   logic               start_ok;
   logic               stop_ok;

   always_comb begin
      post_occ = wr_occ - WQ_OW'(1) + {{(WQ_OW-1){1'b0}}, wpush_acc};
      cnt_inc  = (phase_cnt == CNT_MX) ? phase_cnt : phase_cnt + 1'b1;
      start_ok = (dir == BUS_RD) && !rd_cand && (wr_occ != '0) &&
                 ((wr_occ > LO_V) || drain_req);
      stop_ok  = (dir == BUS_WR) && wpop_acc &&
                 ((post_occ == '0) ||
                  ((post_occ < LO_V) && !drain_req) ||
                  ((rd_occ != '0) && (cnt_inc >= MIN_V)));
   end

   assign tmr_load = stop_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir       <= BUS_RD;
         phase_cnt <= '0;
         wr_start  <= 1'b0;
         rd_resume <= 1'b0;
      end else begin
         wr_start  <= 1'b0;
         rd_resume <= 1'b0;
         unique case (dir)
            BUS_RD: begin
               if (start_ok) begin
                  dir      <= BUS_WR;
                  wr_start <= 1'b1;
               end
            end
            BUS_WR: begin
               if (stop_ok) begin
                  dir       <= BUS_TURN;
                  phase_cnt <= '0;
               end else if (wpop_acc) begin
                  phase_cnt <= cnt_inc;
               end
            end
            BUS_TURN: begin
               if (tmr_expire) begin
                  dir       <= BUS_RD;
                  rd_resume <= 1'b1;
               end
            end
            default: dir <= BUS_RD;
         endcase
      end
   end

   a_r4_start_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |-> (wr_occ != '0) && (dir == BUS_WR));
   a_r5_single_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> !wr_start);
   a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wpop_acc && (dir == BUS_WR) && (phase_cnt != CNT_MX)) |=>
         ((dir == BUS_TURN) || (phase_cnt == $past(phase_cnt) + 1'b1)));
   a_r8_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((dir == BUS_TURN) && ($past(dir) == BUS_WR)) |-> (phase_cnt == '0));
   a_r8_resume_from_turn: assert property (@(posedge clk) disable iff (!rst_n)
      rd_resume |-> ($past(dir) == BUS_TURN) && (dir == BUS_RD));
   a_r10_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
      (dir == BUS_RD) |-> (phase_cnt == '0));
endmodule

// File: rtl/wr_turnaround_arb.sv
module wr_turnaround_arb
   import arb_pkg::*;
#(
   parameter int WQ_DEPTH = 32,
   parameter int RQ_DEPTH = 32,
   parameter int HI_PCT   = 85,
   parameter int LO_PCT   = 50,
   parameter int MIN_WR   = 4,
   parameter int TWTR     = 6,
   parameter int PHASE_W  = 8,
   localparam int WQ_OW   = $clog2(WQ_DEPTH + 1),
   localparam int RQ_OW   = $clog2(RQ_DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wq_push,
   input  logic               rq_push,
   input  logic               rq_pop,
   input  logic               rd_cand,
   input  logic               drain_req,
   input  logic               wr_done,
   output logic [1:0]         bus_dir,
   output logic               wr_start,
   output logic               rd_resume,
   output logic               rd_allow,
   output logic               wq_above_hi,
   output logic [WQ_OW-1:0]   wr_occ,
   output logic [RQ_OW-1:0]   rd_occ,
   output logic [PHASE_W-1:0] phase_cnt
);
   localparam int HI_MARK = pct_of(WQ_DEPTH, HI_PCT);
   localparam int LO_MARK = pct_of(WQ_DEPTH, LO_PCT);
   localparam logic [WQ_OW-1:0] WQ_FULL = WQ_OW'(WQ_DEPTH);
   localparam logic [RQ_OW-1:0] RQ_FULL = RQ_OW'(RQ_DEPTH);

   if (LO_PCT >= HI_PCT) begin : g_bad_marks
      $error("low watermark percent must be below high watermark percent");
   end
   if (HI_PCT > 100 || LO_PCT < 0) begin : g_bad_pct
      $error("watermark percent out of range");
   end
   if (TWTR < 1) begin : g_bad_twtr
      $error("turnaround delay must be at least one cycle");
   end
   if (MIN_WR < 1 || MIN_WR >= (1 << PHASE_W)) begin : g_bad_min
      $error("minimum writes per switch does not fit the phase counter");
   end

   bus_dir_e dir;
   logic     wpush_acc, wpop_acc, rpush_acc, rpop_acc;
   logic     tmr_load, tmr_busy, tmr_expire;

   assign wpush_acc = wq_push && (wr_occ != WQ_FULL);
   assign wpop_acc  = wr_done && (dir == BUS_WR) && (wr_occ != '0);
   assign rpush_acc = rq_push && (rd_occ != RQ_FULL);
   assign rpop_acc  = rq_pop && (rd_occ != '0);

   arb_occ_ctr #(.DEPTH(WQ_DEPTH)) u_wq_occ (
      .clk(clk), .rst_n(rst_n), .inc(wpush_acc), .dec(wpop_acc), .occ(wr_occ));

   arb_occ_ctr #(.DEPTH(RQ_DEPTH)) u_rq_occ (
      .clk(clk), .rst_n(rst_n), .inc(rpush_acc), .dec(rpop_acc), .occ(rd_occ));

   arb_wtr_timer #(.TWTR(TWTR)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load),
      .busy(tmr_busy), .expire(tmr_expire));

   arb_phase_fsm #(
      .WQ_DEPTH(WQ_DEPTH), .LO_MARK(LO_MARK), .MIN_WR(MIN_WR),
      .PHASE_W(PHASE_W), .WQ_OW(WQ_OW), .RQ_OW(RQ_OW)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .rd_cand(rd_cand), .drain_req(drain_req),
      .wr_occ(wr_occ), .rd_occ(rd_occ), .wpush_acc(wpush_acc),
      .wpop_acc(wpop_acc), .tmr_expire(tmr_expire), .tmr_load(tmr_load),
      .dir(dir), .phase_cnt(phase_cnt), .wr_start(wr_start),
      .rd_resume(rd_resume));

   assign bus_dir  = dir;
   assign rd_allow = (dir == BUS_RD);

   if (HI_MARK == 0) begin : g_hi_zero
      assign wq_above_hi = 1'b1;
   end else begin : g_hi_cmp
      assign wq_above_hi = (wr_occ >= WQ_OW'(HI_MARK));
   end

   a_r8_no_read_in_turn: assert property (@(posedge clk) disable iff (!rst_n)
      rd_allow |-> !tmr_busy);
   a_r10_no_pop_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_allow && !wq_push) |=> (wr_occ == $past(wr_occ)) || !$past(rd_allow));
endmodule

// File: tb/test_wr_turnaround_arb.sv
module test_wr_turnaround_arb;
   localparam int WQ_DEPTH = 32;
   localparam int RQ_DEPTH = 32;
   localparam int MIN_WR   = 4;
   localparam int TWTR     = 6;
   localparam int PHASE_W  = 8;
   localparam int HI       = (WQ_DEPTH * 85) / 100;
   localparam int LO       = (WQ_DEPTH * 50) / 100;
   localparam int CMAX     = (1 << PHASE_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wq_push = 0, rq_push = 0, rq_pop = 0, rd_cand = 0, drain_req = 0, wr_done = 0;
   logic [1:0] bus_dir;
   logic wr_start, rd_resume, rd_allow, wq_above_hi;
   logic [5:0] wr_occ, rd_occ;
   logic [PHASE_W-1:0] phase_cnt;

   int checks = 0;
   int fails  = 0;
   int m_dir, m_cnt, m_t, m_wo, m_ro, m_st, m_rs;

   always #2 clk = ~clk;

   wr_turnaround_arb #(.WQ_DEPTH(WQ_DEPTH), .RQ_DEPTH(RQ_DEPTH), .HI_PCT(85),
      .LO_PCT(50), .MIN_WR(MIN_WR), .TWTR(TWTR), .PHASE_W(PHASE_W)) i_wr_turnaround_arb (
      .clk(clk), .rst_n(rst_n), .wq_push(wq_push), .rq_push(rq_push),
      .rq_pop(rq_pop), .rd_cand(rd_cand), .drain_req(drain_req),
      .wr_done(wr_done), .bus_dir(bus_dir), .wr_start(wr_start),
      .rd_resume(rd_resume), .rd_allow(rd_allow), .wq_above_hi(wq_above_hi),
      .wr_occ(wr_occ), .rd_occ(rd_occ), .phase_cnt(phase_cnt));

   task automatic expect_eq(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   function automatic void model_reset();
      m_dir = 0; m_cnt = 0; m_t = 0; m_wo = 0; m_ro = 0; m_st = 0; m_rs = 0;
   endfunction

   function automatic void model_step();
      int wpush, wpop, rpush, rpop, nwo, inc;
      wpush = (wq_push && m_wo != WQ_DEPTH) ? 1 : 0;
      wpop  = (wr_done && m_dir == 1 && m_wo != 0) ? 1 : 0;
      rpush = (rq_push && m_ro != RQ_DEPTH) ? 1 : 0;
      rpop  = (rq_pop && m_ro != 0) ? 1 : 0;
      nwo   = m_wo + wpush - wpop;
      m_st = 0; m_rs = 0;
      case (m_dir)
         0: if (!rd_cand && m_wo != 0 && (m_wo > LO || drain_req)) begin
               m_dir = 1; m_st = 1;
            end
         1: if (wpop == 1) begin
               inc = (m_cnt == CMAX) ? m_cnt : m_cnt + 1;
               if (nwo == 0 || (nwo < LO && !drain_req) || (m_ro != 0 && inc >= MIN_WR)) begin
                  m_dir = 2; m_cnt = 0; m_t = TWTR;
               end else m_cnt = inc;
            end
         default: if (m_t == 1) begin
               m_dir = 0; m_rs = 1; m_t = 0;
            end else m_t = m_t - 1;
      endcase
      m_wo = nwo;
      m_ro = m_ro + rpush - rpop;
   endfunction

   task automatic check_all(input string req);
      expect_eq(req, "bus_dir", int'(bus_dir), m_dir);
      expect_eq(req, "wr_start", int'(wr_start), m_st);
      expect_eq(req, "rd_resume", int'(rd_resume), m_rs);
      expect_eq(req, "rd_allow", int'(rd_allow), (m_dir == 0) ? 1 : 0);
      expect_eq(req, "wr_occ", int'(wr_occ), m_wo);
      expect_eq(req, "rd_occ", int'(rd_occ), m_ro);
      expect_eq(req, "phase_cnt", int'(phase_cnt), m_cnt);
      expect_eq("R2", "wq_above_hi", int'(wq_above_hi), (m_wo >= HI) ? 1 : 0);
   endtask

   task automatic tick(input string req);
      model_step();
      @(negedge clk);
      check_all(req);
   endtask

   task automatic quiet();
      wq_push = 0; rq_push = 0; rq_pop = 0; rd_cand = 0; drain_req = 0; wr_done = 0;
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R10: completions in read direction are ignored
      rd_cand = 1;
      wq_push = 1;
      repeat (3) tick("R3");
      wq_push = 0; wr_done = 1;
      repeat (3) tick("R10");
      wr_done = 0;
      expect_eq("R10", "wr_occ after stray done", int'(wr_occ), 3);
      expect_eq("R10", "phase_cnt after stray done", int'(phase_cnt), 0);

      // R4: at or below low mark without drain, no phase opens
      rd_cand = 0;
      repeat (4) tick("R4");
      expect_eq("R4", "bus_dir below low mark", int'(bus_dir), 0);

      // R9: drain opens the phase and empties the queue
      drain_req = 1;
      tick("R9");
      expect_eq("R4", "wr_start on drain", int'(wr_start), 1);
      wr_done = 1;
      repeat (3) tick("R9");
      wr_done = 0; drain_req = 0; rd_cand = 1;
      expect_eq("R9", "bus_dir after drain empty", int'(bus_dir), 2);
      expect_eq("R8", "phase_cnt cleared", int'(phase_cnt), 0);
      n = 0;
      while (bus_dir == 2 && n < 20) begin
         tick("R8");
         n++;
      end
      expect_eq("R8", "turnaround cycles", n, TWTR);
      expect_eq("R8", "rd_resume pulse", int'(rd_resume), 1);

      // R7 minimum writes with reads waiting
      wq_push = 1; rq_push = 1;
      repeat (2) tick("R3");
      rq_push = 0;
      repeat (28) tick("R3");
      wq_push = 0;
      expect_eq("R2", "above high mark at 30", int'(wq_above_hi), 1);
      rd_cand = 0;
      tick("R4");
      wr_done = 1;
      repeat (MIN_WR) tick("R7");
      wr_done = 0; rd_cand = 1;
      expect_eq("R7", "stop after min writes", int'(bus_dir), 2);
      expect_eq("R7", "wr_occ after min writes", int'(wr_occ), 30 - MIN_WR);
      repeat (TWTR) tick("R8");

      // R7 low mark exit with no reads waiting
      rq_pop = 1;
      repeat (2) tick("R3");
      rq_pop = 0; rd_cand = 0;
      tick("R4");
      wr_done = 1;
      n = 0;
      while (bus_dir == 1 && n < 40) begin
         tick("R7");
         n++;
      end
      wr_done = 0; rd_cand = 1;
      expect_eq("R7", "completions to low mark", n, 30 - MIN_WR - (LO - 1));
      expect_eq("R7", "wr_occ at low exit", int'(wr_occ), LO - 1);
      repeat (TWTR) tick("R8");

      // R6 saturation under drain with matched push and completion
      drain_req = 1; rd_cand = 0;
      tick("R9");
      wq_push = 1; wr_done = 1;
      repeat (300) tick("R6");
      expect_eq("R6", "phase_cnt saturated", int'(phase_cnt), CMAX);
      expect_eq("R5", "still one phase", int'(bus_dir), 1);
      wq_push = 0;
      repeat (LO - 1) tick("R9");
      wr_done = 0; drain_req = 0;
      expect_eq("R9", "drain ends on empty", int'(bus_dir), 2);
      repeat (TWTR) tick("R8");

      // random mix
      for (int i = 0; i < 6000; i++) begin
         wq_push   = ($urandom % 100) < 45;
         rq_push   = ($urandom % 100) < 20;
         rq_pop    = ($urandom % 100) < 20;
         rd_cand   = ($urandom % 100) < 35;
         wr_done   = ($urandom % 100) < 50;
         if (($urandom % 64) == 0) drain_req = ~drain_req;
         tick("R5");
      end
      quiet();
      tick("R3");
      summary();
      $finish;
   end
endmodule